// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block turns one burst request into the run of column addresses that a memory controller issues to an open SDRAM row, one address per clock. A one-cycle start pulse carries the starting column, a burst length code, the ordering (sequential or interleaved), a read/write flag and a single-write mode bit. From the next cycle on the block presents a column with a valid flag, and it raises a last flag together with the final beat of a finite burst.

A full-page burst steps through the whole 512-column row and wraps from the top column back to zero. It runs until the controller ends it. A new start pulse may arrive in any cycle and replaces the burst in flight; this is how random column access works. A terminate input stops the burst without starting a new one. When single-write mode is set, every write lasts one beat while reads keep the programmed length.

Top module: `sdram_burst_seq`

## Requirements
- R1: While reset is low and in the first cycle after it, `valid_o` and `last_o` are 0 and `col_o` is 0.
- R2: Length code values 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. Any code with bit 2 set gives a full-page burst.
- R3: In sequential order, beat k presents the column whose bits below log2(length) equal (start + k) modulo the length. The bits above that block keep the value they have in the starting column.
- R4: In interleaved order (`interleave_i`=1), beat k of a finite burst presents the starting column XOR k. A full-page burst ignores `interleave_i` and runs in sequential order.
- R5: The first beat appears in the cycle after the start pulse and carries the starting column. Each following beat appears one cycle after the one before it.
- R6: `last_o` is high with the final beat of a finite burst and at no other time. In the cycle after that beat `valid_o` is 0, unless a new start was given.
- R7: A full-page burst adds 1 to the column on every beat, goes from 511 to 0, keeps running until it is stopped, and never raises `last_o`.
- R8: When `term_i` is high and `start_i` is low, `valid_o` and `last_o` are 0 in the next cycle.
- R9: A start pulse during a burst, including during its final beat, begins the new burst in the next cycle. When `start_i` and `term_i` are high in the same cycle, the start takes effect.
- R10: When `is_write_i`=1 and `single_write_i`=1, the burst has one beat with `last_o` high, whatever the length code. Reads and writes with `single_write_i`=0 use the length code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin a burst |
| start_col_i | input | 9 | Starting column |
| blen_code_i | input | 3 | Length code: 0..3 give 1/2/4/8 beats; bit 2 set gives full page |
| interleave_i | input | 1 | 1 = interleaved order, 0 = sequential order |
| is_write_i | input | 1 | 1 = the burst is a write |
| single_write_i | input | 1 | 1 = every write lasts one beat |
| term_i | input | 1 | Stop the running burst |
| col_o | output | 9 | Column of the current beat |
| valid_o | output | 1 | `col_o` holds a beat |
| last_o | output | 1 | Final beat of a finite burst |

## Verification
Three controls can fall in the same cycle: a new start, a terminate, and the natural end of a burst. The bench drives a start together with a terminate, a start during the final beat of a burst, and a terminate partway through a full-page run. In each case it checks that the start wins, that back-to-back bursts follow each other without a gap, and that a terminate on its own leaves the next cycle idle. A behavioural model built on queues predicts every beat, and the bench compares it with the outputs on every clock.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int COL_W  = 9;
  localparam int CODE_W = 3;

  typedef logic [COL_W-1:0] col_t;

  // all-ones mask covering the low bits of an aligned block of 2**code columns
  function automatic col_t block_mask(input logic [1:0] code);
    col_t m;
    m = '0;
    for (int i = 0; i < 3; i++)
      if (i < int'(code)) m[i] = 1'b1;
    return m;
  endfunction

  // sequential: count inside the masked block, the bits above it are held
  function automatic col_t seq_col(input col_t base, input col_t cnt, input col_t mask);
    col_t sum;
    sum = base + cnt;
    return (base & ~mask) | (sum & mask);
  endfunction

  // interleaved: the low bits are XORed with the beat count
  function automatic col_t ilv_col(input col_t base, input col_t cnt, input col_t mask);
    return (base & ~mask) | ((base ^ cnt) & mask);
  endfunction
endpackage

// File: rtl/sbs_len_decode.sv
module sbs_len_decode
  import sbs_pkg::*;
#(
  parameter int CW = CODE_W
) (
  input  logic [CW-1:0] code_i,
  input  logic          is_write_i,
  input  logic          single_write_i,
  output col_t          mask_o,
  output logic          full_o
);
  logic one_beat;

  assign one_beat = is_write_i & single_write_i;
  assign full_o   = code_i[2] & ~one_beat;
  assign mask_o   = one_beat  ? '0 :
                    code_i[2] ? '1 : block_mask(code_i[1:0]);
endmodule

// File: rtl/sbs_beat_ctrl.sv
module sbs_beat_ctrl
  import sbs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  col_t start_col_i,
  input  col_t mask_i,
  input  logic full_i,
  input  logic ilv_i,
  input  logic term_i,
  output col_t base_o,
  output col_t cnt_o,
  output col_t mask_o,
  output logic full_o,
  output logic ilv_o,
  output logic valid_o,
  output logic last_o,
  output logic beat_adv_o
);
  col_t cnt_nxt;

  assign cnt_nxt    = cnt_o + col_t'(1);
  assign beat_adv_o = valid_o & ~last_o & ~term_i & ~start_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_o  <= '0;
      cnt_o   <= '0;
      mask_o  <= '0;
      full_o  <= 1'b0;
      ilv_o   <= 1'b0;
      valid_o <= 1'b0;
      last_o  <= 1'b0;
    end else if (start_i) begin
      base_o  <= start_col_i;
      cnt_o   <= '0;
      mask_o  <= mask_i;
      full_o  <= full_i;
      ilv_o   <= ilv_i;
      valid_o <= 1'b1;
      last_o  <= ~full_i & (mask_i == '0);
    end else if (term_i || last_o) begin
      valid_o <= 1'b0;
      last_o  <= 1'b0;
    end else if (valid_o) begin
      cnt_o  <= cnt_nxt;
      last_o <= ~full_o & (cnt_nxt == mask_o);
    end
  end
endmodule

// File: rtl/sbs_addr_gen.sv
module sbs_addr_gen
  import sbs_pkg::*;
(
  input  col_t base_i,
  input  col_t cnt_i,
  input  col_t mask_i,
  input  logic full_i,
  input  logic ilv_i,
  output col_t col_o
);
  always_comb begin
    if (ilv_i && !full_i) col_o = ilv_col(base_i, cnt_i, mask_i);
    else                  col_o = seq_col(base_i, cnt_i, mask_i);
  end
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic [CODE_W-1:0] blen_code_i,
  input  logic              interleave_i,
  input  logic              is_write_i,
  input  logic              single_write_i,
  input  logic              term_i,
  output logic [COL_W-1:0]  col_o,
  output logic              valid_o,
  output logic              last_o
);
  col_t dec_mask;
  logic dec_full;
  col_t base_q, cnt_q, mask_q;
  logic full_q, ilv_q;
  logic beat_adv;

  sbs_len_decode #(.CW(CODE_W)) u_dec (
    .code_i         (blen_code_i),
    .is_write_i     (is_write_i),
    .single_write_i (single_write_i),
    .mask_o         (dec_mask),
    .full_o         (dec_full)
  );

  sbs_beat_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .mask_i      (dec_mask),
    .full_i      (dec_full),
    .ilv_i       (interleave_i),
    .term_i      (term_i),
    .base_o      (base_q),
    .cnt_o       (cnt_q),
    .mask_o      (mask_q),
    .full_o      (full_q),
    .ilv_o       (ilv_q),
    .valid_o     (valid_o),
    .last_o      (last_o),
    .beat_adv_o  (beat_adv)
  );

  sbs_addr_gen u_addr (
    .base_i (base_q),
    .cnt_i  (cnt_q),
    .mask_i (mask_q),
    .full_i (full_q),
    .ilv_i  (ilv_q),
    .col_o  (col_o)
  );
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker
  import sbs_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input col_t start_col_i,
  input logic is_write_i,
  input logic single_write_i,
  input logic term_i,
  input col_t col_o,
  input logic valid_o,
  input logic last_o,
  input col_t mask_q,
  input logic full_q,
  input logic ilv_q,
  input logic beat_adv
);
  a_r5_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> valid_o && col_o == $past(start_col_i));

  a_r6_last_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);

  a_r6_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_o && !start_i |=> !valid_o);

  a_r7_full_no_last: assert property (@(posedge clk) disable iff (!rst_n)
    full_q && valid_o |-> !last_o);

  a_r7_full_step: assert property (@(posedge clk) disable iff (!rst_n)
    beat_adv && full_q |=> valid_o && col_o == $past(col_o) + 9'd1);

  a_r3_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    beat_adv && !full_q && !ilv_q |=>
      ((col_o & ~mask_q) == ($past(col_o) & ~mask_q)) &&
      ((col_o & mask_q) == (($past(col_o) + 9'd1) & mask_q)));

  a_r8_term_stops: assert property (@(posedge clk) disable iff (!rst_n)
    term_i && !start_i |=> !valid_o && !last_o);

  a_r10_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && is_write_i && single_write_i |=> last_o);
endmodule

bind sdram_burst_seq sbs_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start_i        (start_i),
  .start_col_i    (start_col_i),
  .is_write_i     (is_write_i),
  .single_write_i (single_write_i),
  .term_i         (term_i),
  .col_o          (col_o),
  .valid_o        (valid_o),
  .last_o         (last_o),
  .mask_q         (mask_q),
  .full_q         (full_q),
  .ilv_q          (ilv_q),
  .beat_adv       (beat_adv)
);

// File: tb/test_sdram_burst_seq.sv
module test_sdram_burst_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [8:0] start_col_i = '0;
  logic [2:0] blen_code_i = '0;
  logic       interleave_i = 1'b0;
  logic       is_write_i = 1'b0;
  logic       single_write_i = 1'b0;
  logic       term_i = 1'b0;
  logic [8:0] col_o;
  logic       valid_o, last_o;

  int compared = 0, mismatched = 0;
  string cur_req = "R1";
  bit finished = 0;

  sdram_burst_seq i_sdram_burst_seq (.*);

  always #5 clk = ~clk;

  // behavioural reference model
  int  q[$];
  bit  m_valid = 0, m_last = 0, m_full = 0;
  int  m_col = 0, m_start = 0, m_k = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0; m_last = 0; m_full = 0; m_col = 0; q.delete();
    end else if (start_i) begin
      int len, s;
      s = int'(start_col_i);
      len = blen_code_i[2] ? 0 : (1 << blen_code_i[1:0]);
      if (is_write_i && single_write_i) len = 1;
      q.delete();
      m_valid = 1; m_start = s; m_k = 0;
      if (len == 0) begin
        m_full = 1; m_col = s; m_last = 0;
      end else begin
        m_full = 0;
        for (int i = 0; i < len; i++)
          if (interleave_i) q.push_back(s ^ i);
          else              q.push_back(s - (s % len) + ((s % len + i) % len));
        m_col = q.pop_front();
        m_last = (q.size() == 0);
      end
    end else if (term_i) begin
      m_valid = 0; m_last = 0;
    end else if (m_valid) begin
      if (m_full) begin
        m_k++; m_col = (m_start + m_k) % 512;
      end else if (q.size() != 0) begin
        m_col = q.pop_front(); m_last = (q.size() == 0);
      end else begin
        m_valid = 0; m_last = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      bit bad;
      bad = (valid_o !== m_valid) || (last_o !== m_last) ||
            (m_valid && col_o !== 9'(m_col)) || (!rst_n && col_o !== 9'd0);
      compared++;
      if (bad) begin
        mismatched++;
        $display("FAIL %s: got valid=%0b last=%0b col=%0d, expected valid=%0b last=%0b col=%0d",
                 cur_req, valid_o, last_o, col_o, m_valid, m_last, m_col);
      end
    end
  end

  task automatic go(input string req, input int col, input int code, input bit ilv,
                    input bit wr, input bit sw, input bit trm, input int wait_cyc);
    @(negedge clk);
    cur_req = req;
    start_i = 1; start_col_i = 9'(col); blen_code_i = 3'(code);
    interleave_i = ilv; is_write_i = wr; single_write_i = sw; term_i = trm;
    @(negedge clk);
    start_i = 0; term_i = 0;
    repeat (wait_cyc) @(negedge clk);
  endtask

  task automatic stop(input string req);
    @(negedge clk);
    cur_req = req; term_i = 1;
    @(negedge clk);
    term_i = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      mismatched++;
      $display("FAIL watchdog: got running, expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";                                // R1 reset state
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    go("R2/R3 seq len8 wrap", 29, 3, 0, 0, 0, 0, 10);
    go("R3 seq len4 top block", 510, 2, 0, 0, 0, 0, 6);
    go("R2 len2", 7, 1, 0, 0, 0, 0, 4);
    go("R2 len1", 100, 0, 0, 0, 0, 0, 3);
    go("R4 ilv len8", 29, 3, 1, 0, 0, 0, 10);
    go("R4 ilv len4", 258, 2, 1, 0, 0, 0, 6);
    go("R4 ilv len2", 13, 1, 1, 0, 0, 0, 4);
    go("R7 full page wrap", 505, 7, 0, 0, 0, 0, 12);
    stop("R8 term full page");
    go("R4 full page ignores ilv", 3, 4, 1, 0, 0, 0, 5);
    stop("R8 term");
    go("R10 single write", 40, 3, 0, 1, 1, 0, 4);
    go("R10 read in single mode", 40, 3, 0, 0, 1, 0, 10);
    go("R10 write burst mode", 40, 3, 0, 1, 0, 0, 10);
    go("R10 single write full code", 41, 7, 0, 1, 1, 0, 4);
    go("R8 term mid burst", 64, 3, 0, 0, 0, 0, 2);
    stop("R8 term mid burst");
    go("R9 restart mid burst", 80, 3, 0, 0, 0, 0, 2);
    go("R9 new burst", 200, 2, 1, 0, 0, 0, 1);
    go("R9 start with term", 300, 3, 0, 0, 0, 1, 10);
    go("R9 back to back a", 16, 1, 0, 0, 0, 0, 0);
    go("R9 back to back b", 33, 1, 0, 0, 0, 0, 0);
    go("R9 back to back c", 60, 2, 1, 0, 0, 0, 6);
    go("R5/R6 len8 interleaved high col", 511, 3, 1, 0, 0, 0, 10);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule